// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

The block drives the six switches of a three-phase motor inverter. One 10-bit time-base counter is shared by the three phases U, V and W. Each phase has a compare value. The phase signal is high while the count is below that compare value. Each phase produces a high-side output and its complement on a low-side output. Every output has its own rising-edge delay, so the two switches of a leg never conduct together.

The counter runs in one of two modes. In edge-aligned mode it counts up and wraps. In centre-aligned mode it counts up and then back down. Period, compare values, mode and repetition count are written into shadow registers. They take effect only at an update event. A repetition counter sets how many periods pass between update events. An emergency-stop input forces every output low at once, without waiting for a clock edge. The outputs stay low until software clears the latched stop flag. Eight sticky status flags, each with its own enable, drive a single interrupt line.

Top module: `pwm3_top`

## Requirements
- R1: After reset, all six PWM outputs, all eight flags and the interrupt are low, and the time base is stopped.
- R2: Edge-aligned mode (control bit 1 = 0) works as follows. The counter runs 0,1,..,P and wraps, so one period is P+1 cycles. The raw phase signal is high while count < compare. Output bit 2p is the high side of phase p (p = 0 U, 1 V, 2 W) and follows the raw signal. Bit 2p+1 is the low side and follows its complement.
- R3: Centre-aligned mode (control bit 1 = 1) works as follows. The counter runs up from 0 to P and back down to 0, so one period is 2P cycles. A compare value C gives a contiguous raw high time of 2C-1 cycles per period.
- R4: A compare value of 0 keeps the high side low and the low side high for the whole period. A compare value at or above P keeps the high side high and the low side low.
- R5: Each output has its own 6-bit delay D, applied to its rising edge only. A high pulse is therefore D cycles shorter than its raw signal. The two outputs of a phase are never high together.
- R6: Period, compare, mode and repetition values that software writes are used only from the next update event. A period already in progress is never changed.
- R7: With repetition value N, an update event occurs every N+1 periods. Each such event sets flag bit 7 (repetition expired) and flag bit 0 (update).
- R8: Raising the emergency-stop input drives all outputs low immediately, with no clock edge needed, and sets flag bit 1. The outputs stay low after the input falls, until flag bit 1 is cleared while the input is low. A clear written while the input is still high has no effect.
- R9: The flags are sticky and cleared by writing 1 to their bits at address 6. The bits are: 0 update (also set when the time base starts), 1 emergency stop, 2/3/4 count equals compare U/V/W, 5 count equals zero, 6 count equals period, 7 repetition expired. The interrupt is high while any flag is set whose bit is also set in the enable register.
- R10: Configuration writes use a single-cycle strobe with this address map: 0 period, 1-3 compare U/V/W, 4 repetition, 5 control (bit 0 run, bit 1 centre mode), 6 flag clear, 7 interrupt enable, 8-13 delay for output bits 0-5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 10 | Configuration write data |
| estop | input | 1 | Asynchronous emergency stop, active high |
| pwm_out | output | 6 | High/low side pairs for U, V, W (high side on even bits) |
| flags | output | 8 | Sticky status flags |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures pulse widths in edge-aligned mode and in centre-aligned mode, with several compare values and unequal delays on the two sides of a leg. A wrong count direction, a wrong turn-around point or a delay applied to the wrong edge each gives a different width. Compare values of zero and of at least the period are run to separate the saturated cases from ordinary ones. A compare change is written just after an update while the repetition count is 3. Its pulse widths show whether the change waits four periods or takes effect early. The spacing of update flags is timed in both modes. The emergency stop is raised between clock edges to show that it acts without a clock, and a clear is written while the input is still high to show that the clear is ignored.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  parameter int unsigned CNT_W = 10;
  parameter int unsigned DLY_W = 6;
  parameter int unsigned REP_W = 8;
  parameter int unsigned N_PH  = 3;

  // configuration addresses
  localparam int unsigned AD_PRD  = 0;
  localparam int unsigned AD_CMP0 = 1;
  localparam int unsigned AD_REP  = 4;
  localparam int unsigned AD_CTRL = 5;
  localparam int unsigned AD_CLR  = 6;
  localparam int unsigned AD_IEN  = 7;
  localparam int unsigned AD_DLY0 = 8;

  // flag bit positions
  localparam int unsigned FB_UPD  = 0;
  localparam int unsigned FB_STOP = 1;
  localparam int unsigned FB_CMP0 = 2;
  localparam int unsigned FB_ZERO = 5;
  localparam int unsigned FB_TOP  = 6;
  localparam int unsigned FB_REP  = 7;
endpackage

// File: rtl/pwm3_timebase.sv
module pwm3_timebase #(
  parameter int unsigned CW = pwm3_pkg::CNT_W,
  parameter int unsigned RW = pwm3_pkg::REP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          centre_sh,
  input  logic [CW-1:0] prd_sh,
  input  logic [RW-1:0] rep_sh,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] prd_act,
  output logic          evt_start,
  output logic          evt_upd
);
  logic          down, ctr_act, run_q, wrap;
  logic [RW-1:0] rep_cnt;
  logic [CW:0]   nxt;

  // end of a period: the next count starts a fresh period
  function automatic logic f_wrap(input logic [CW-1:0] c, input logic dn,
                                  input logic [CW-1:0] p, input logic ctr);
    if (!ctr || p == '0) return c >= p;
    return dn && (c == '0);
  endfunction

  // next {direction, count}
  function automatic logic [CW:0] f_next(input logic [CW-1:0] c, input logic dn,
                                         input logic [CW-1:0] p, input logic ctr);
    if (!ctr || p == '0) return (c >= p) ? {1'b0, {CW{1'b0}}} : {1'b0, c + 1'b1};
    if (!dn) return (c >= p) ? {1'b1, p - 1'b1} : {1'b0, c + 1'b1};
    return (c == '0) ? {1'b0, CW'(1)} : {1'b1, c - 1'b1};
  endfunction

  assign wrap      = f_wrap(cnt, down, prd_act, ctr_act);
  assign nxt       = f_next(cnt, down, prd_act, ctr_act);
  assign evt_upd   = run && wrap && (rep_cnt == '0);
  assign evt_start = run && !run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; down <= 1'b0; rep_cnt <= '0;
      prd_act <= '0; ctr_act <= 1'b0; run_q <= 1'b0;
    end else begin
      run_q <= run;
      if (!run) begin
        cnt <= '0; down <= 1'b0; rep_cnt <= rep_sh;
        prd_act <= prd_sh; ctr_act <= centre_sh;
      end else begin
        {down, cnt} <= nxt;
        if (wrap) begin
          if (rep_cnt == '0) begin
            rep_cnt <= rep_sh; prd_act <= prd_sh; ctr_act <= centre_sh;
          end else begin
            rep_cnt <= rep_cnt - 1'b1;
          end
        end
      end
    end
  end

  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= prd_act);
  a_r7_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    evt_upd |=> rep_cnt == $past(rep_sh));
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wrap && rep_cnt != '0) |=> rep_cnt == $past(rep_cnt) - 1'b1);
endmodule

// File: rtl/pwm3_deadband.sv
module pwm3_deadband #(
  parameter int unsigned DW = pwm3_pkg::DLY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [DW-1:0] dly,
  output logic          dout
);
  logic [DW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0; dout <= 1'b0;
    end else if (!din) begin
      wait_cnt <= '0; dout <= 1'b0;
    end else if (wait_cnt >= dly) begin
      dout <= 1'b1;
    end else begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end

  a_r5_fall_prompt: assert property (@(posedge clk) disable iff (!rst_n)
    !din |=> !dout);
  a_r5_rise_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout) |-> $past(din));
endmodule

// File: rtl/pwm3_estop.sv
module pwm3_estop (
  input  logic clk,
  input  logic rst_n,
  input  logic estop,
  input  logic clr,
  output logic stop_lat,
  output logic safe
);
  always_ff @(posedge clk or negedge rst_n or posedge estop) begin
    if (!rst_n)     stop_lat <= 1'b0;
    else if (estop) stop_lat <= 1'b1;
    else if (clr)   stop_lat <= 1'b0;
  end

  assign safe = estop | stop_lat;

  a_r8_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_lat && !clr) |=> stop_lat);
  a_r8_clear_ignored_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    estop |=> stop_lat);
endmodule

// File: rtl/pwm3_top.sv
module pwm3_top
  import pwm3_pkg::*;
#(
  parameter int unsigned CW  = CNT_W,
  parameter int unsigned DW  = DLY_W,
  parameter int unsigned RW  = REP_W,
  parameter int unsigned NPH = N_PH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [3:0]     cfg_addr,
  input  logic [CW-1:0]  cfg_wdata,
  input  logic           estop,
  output logic [2*NPH-1:0] pwm_out,
  output logic [7:0]     flags,
  output logic           irq
);
  localparam int unsigned NOUT = 2 * NPH;

  logic [CW-1:0] prd_sh, cnt, prd_act;
  logic [CW-1:0] cmp_sh  [NPH];
  logic [CW-1:0] cmp_act [NPH];
  logic [DW-1:0] dly_r   [NOUT];
  logic [RW-1:0] rep_sh;
  logic [7:0]    ien_r, clr_mask, ev;
  logic [5:0]    flg_hi;
  logic          flg_up, run, centre_sh, evt_start, evt_upd;
  logic          stop_lat, safe, go;
  logic [NPH-1:0]  raw;
  logic [NOUT-1:0] side_in, db_q;
  int unsigned   ai;

  function automatic logic f_high(input logic [CW-1:0] c, input logic [CW-1:0] cmp,
                                  input logic [CW-1:0] p);
    return (cmp >= p) || (c < cmp);
  endfunction

  assign ai       = 32'(cfg_addr);
  assign clr_mask = (cfg_we && ai == AD_CLR) ? cfg_wdata[7:0] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_sh <= CW'(100); rep_sh <= '0; run <= 1'b0; centre_sh <= 1'b0; ien_r <= '0;
      for (int p = 0; p < NPH; p++) cmp_sh[p] <= '0;
      for (int i = 0; i < NOUT; i++) dly_r[i] <= '0;
    end else if (cfg_we) begin
      if (ai == AD_PRD) prd_sh <= cfg_wdata;
      if (ai == AD_REP) rep_sh <= cfg_wdata[RW-1:0];
      if (ai == AD_CTRL) begin run <= cfg_wdata[0]; centre_sh <= cfg_wdata[1]; end
      if (ai == AD_IEN) ien_r <= cfg_wdata[7:0];
      for (int p = 0; p < NPH; p++)
        if (ai == AD_CMP0 + p) cmp_sh[p] <= cfg_wdata;
      for (int i = 0; i < NOUT; i++)
        if (ai == AD_DLY0 + i) dly_r[i] <= cfg_wdata[DW-1:0];
    end
  end

  pwm3_timebase #(.CW(CW), .RW(RW)) i_tb (
    .clk(clk), .rst_n(rst_n), .run(run), .centre_sh(centre_sh), .prd_sh(prd_sh),
    .rep_sh(rep_sh), .cnt(cnt), .prd_act(prd_act), .evt_start(evt_start), .evt_upd(evt_upd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPH; p++) cmp_act[p] <= '0;
    end else if (!run || evt_upd) begin
      for (int p = 0; p < NPH; p++) cmp_act[p] <= cmp_sh[p];
    end
  end

  pwm3_estop i_stop (
    .clk(clk), .rst_n(rst_n), .estop(estop), .clr(clr_mask[FB_STOP]),
    .stop_lat(stop_lat), .safe(safe));

  assign go = run && !stop_lat;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    assign raw[p]           = f_high(cnt, cmp_act[p], prd_act);
    assign side_in[2*p]     = go &&  raw[p];
    assign side_in[2*p + 1] = go && !raw[p];
    a_r5_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwm_out[2*p] && pwm_out[2*p + 1]));
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    pwm3_deadband #(.DW(DW)) i_db (
      .clk(clk), .rst_n(rst_n), .din(side_in[i]), .dly(dly_r[i]), .dout(db_q[i]));
    assign pwm_out[i] = db_q[i] & ~safe;
  end

  always_comb begin
    ev = '0;
    ev[FB_UPD]  = evt_start || evt_upd;
    ev[FB_ZERO] = run && cnt == '0;
    ev[FB_TOP]  = run && cnt == prd_act;
    ev[FB_REP]  = evt_upd;
    for (int p = 0; p < NPH; p++) ev[FB_CMP0 + p] = run && cnt == cmp_act[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_up <= 1'b0; flg_hi <= '0;
    end else begin
      flg_up <= (flg_up & ~clr_mask[FB_UPD]) | ev[FB_UPD];
      flg_hi <= (flg_hi & ~clr_mask[7:2]) | ev[7:2];
    end
  end

  assign flags = {flg_hi, stop_lat, flg_up};
  assign irq   = |(flags & ien_r);

  a_r8_outputs_safe: assert property (@(posedge clk) disable iff (!rst_n)
    (estop || stop_lat) |-> pwm_out == '0);
  a_r6_cmp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !evt_upd) |=> $stable(cmp_act[0]));
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FB_ZERO] && !clr_mask[FB_ZERO]) |=> flags[FB_ZERO]);
endmodule

// File: tb/test_pwm3_top.sv
module test_pwm3_top;
  logic       clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, estop = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [9:0] cfg_wdata = '0;
  wire  [5:0] pwm_out;
  wire  [7:0] flags;
  wire        irq;

  pwm3_top i_pwm3_top (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .estop(estop), .pwm_out(pwm_out), .flags(flags), .irq(irq));

  always #5 clk = ~clk;

  int cyc = 0, n_chk = 0, n_bad = 0, overlap = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // scoreboard: expected pulse widths queued by the driver, popped by the monitor
  int    exp_q[$];
  string tag_q[$];
  int    mon_idx = 0, run_len = 0, e_w;
  bit    mon_on = 1'b0;
  string e_t;

  always @(negedge clk) begin
    if (mon_on) begin
      if (pwm_out[mon_idx]) run_len++;
      else if (run_len > 0) begin
        if (exp_q.size() > 0) begin
          e_w = exp_q.pop_front(); e_t = tag_q.pop_front();
          chk(run_len == e_w, e_t, run_len, e_w);
        end
        run_len = 0;
      end
    end
  end

  // R5: a leg's two outputs must never be high together
  always @(negedge clk)
    if (rst_n)
      for (int p = 0; p < 3; p++)
        if (pwm_out[2*p] && pwm_out[2*p+1]) overlap++;

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 10'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input int w, input int n, input string tag);
    for (int k = 0; k < n; k++) begin exp_q.push_back(w); tag_q.push_back(tag); end
  endtask

  task automatic arm(input int idx);
    mon_idx = idx; run_len = 0; mon_on = 1'b1;
  endtask

  task automatic drain();
    for (int k = 0; k < 3000 && exp_q.size() > 0; k++) @(negedge clk);
    while (exp_q.size() > 0) chk(1'b0, tag_q.pop_front(), -1, exp_q.pop_front());
    mon_on = 1'b0; run_len = 0;
  endtask

  task automatic measure(input int idx, input int w, input int n, input string tag);
    @(negedge clk);
    while (pwm_out[idx]) @(negedge clk);
    arm(idx);
    push(w, n, tag);
    drain();
  endtask

  task automatic wait_upd(output int t);
    int k = 0;
    while (!flags[0] && k < 3000) begin @(negedge clk); k++; end
    t = cyc;
  endtask

  task automatic count_high(input int idx, output int hi);
    hi = 0;
    for (int k = 0; k < 50; k++) begin @(negedge clk); hi += int'(pwm_out[idx]); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int t0, t1, hi, lo;
    logic [7:0] fsnap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(pwm_out == 6'd0, "R1 outputs after reset", int'(pwm_out), 0);
    chk(flags == 8'd0, "R1 flags after reset", int'(flags), 0);
    chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);

    // R10 map: period 20, compares 5/12/20, delays UH=2 UL=3, run edge-aligned
    wr(0, 20); wr(1, 5); wr(2, 12); wr(3, 20); wr(4, 0);
    wr(8, 2); wr(9, 3); wr(5, 1);
    repeat (50) @(negedge clk);

    // R2 + R5 edge-aligned widths: raw widths 5/16 and 12/9, minus per-output delay
    measure(0, 3, 3, "R2 UH width");
    measure(1, 13, 3, "R2 UL width");
    measure(2, 12, 2, "R2 VH width");
    measure(3, 9, 2, "R2 VL width");

    // R4 compare at period, then compare 0
    count_high(4, hi); count_high(5, lo);
    chk(hi == 50, "R4 cmp>=P high side", hi, 50);
    chk(lo == 0, "R4 cmp>=P low side", lo, 0);
    wr(3, 0);
    repeat (30) @(negedge clk);
    count_high(4, hi); count_high(5, lo);
    chk(hi == 0, "R4 cmp=0 high side", hi, 0);
    chk(lo == 50, "R4 cmp=0 low side", lo, 50);

    // R6 compare written just after an update waits for the next one (repetition 3)
    wr(4, 3);
    repeat (30) @(negedge clk);
    wr(6, 1);
    wait_upd(t0);
    arm(0);
    push(3, 4, "R6 old compare kept");
    push(7, 1, "R6 new compare at update");
    wr(1, 9);
    drain();

    // R7 update spacing: 4 periods of 21 cycles
    wr(6, 8'h81);
    wait_upd(t0);
    chk(flags[7] == 1'b1, "R7 repetition flag", int'(flags[7]), 1);
    wr(6, 1);
    wait_upd(t1);
    chk(t1 - t0 == 84, "R7 edge update spacing", t1 - t0, 84);

    // R3 centre-aligned, VL delay 9
    wr(4, 0); wr(5, 3); wr(11, 9);
    repeat (200) @(negedge clk);
    measure(0, 15, 2, "R3 UH width");
    measure(1, 20, 2, "R3 UL width");
    measure(2, 23, 2, "R3 VH width");
    measure(3, 8, 2, "R5 VL delay 9");
    wr(4, 1);
    repeat (100) @(negedge clk);
    wr(6, 1); wait_upd(t0);
    wr(6, 1); wait_upd(t1);
    chk(t1 - t0 == 80, "R7 centre update spacing", t1 - t0, 80);

    // R9 event flags, write-1-to-clear, interrupt enable
    wr(6, 8'hFF);
    repeat (50) @(negedge clk);
    chk(flags[6:2] == 5'h1F, "R9 compare/zero/period flags", int'(flags[6:2]), 31);
    wr(5, 2);
    repeat (3) @(negedge clk);
    fsnap = flags;
    wr(7, 8'h20);
    chk(irq == 1'b1, "R9 irq enabled flag", int'(irq), 1);
    wr(6, 8'h20);
    chk(flags == (fsnap & 8'hDF), "R9 selective clear", int'(flags), int'(fsnap & 8'hDF));
    chk(irq == 1'b0, "R9 irq after clear", int'(irq), 0);
    wr(4, 255); wr(6, 8'hFF); wr(5, 1);
    repeat (3) @(negedge clk);
    chk(flags[0] == 1'b1, "R9 start sets update flag", int'(flags[0]), 1);
    chk(flags[7] == 1'b0, "R9 start leaves repetition flag", int'(flags[7]), 0);

    // R8 emergency stop
    repeat (10) @(negedge clk);
    chk(pwm_out[5] == 1'b1, "R8 WL high before stop", int'(pwm_out[5]), 1);
    wr(7, 8'h02);
    @(negedge clk);
    #2 estop = 1'b1;
    #1 chk(pwm_out == 6'd0, "R8 immediate forcing", int'(pwm_out), 0);
    wr(6, 2);
    chk(flags[1] == 1'b1, "R8 clear ignored while held", int'(flags[1]), 1);
    @(negedge clk);
    estop = 1'b0;
    repeat (10) @(negedge clk);
    chk(pwm_out == 6'd0, "R8 stays safe after release", int'(pwm_out), 0);
    chk(irq == 1'b1, "R8 stop interrupt", int'(irq), 1);
    wr(6, 2);
    repeat (5) @(negedge clk);
    chk(pwm_out[5] == 1'b1, "R8 resumes after clear", int'(pwm_out[5]), 1);
    chk(flags[1] == 1'b0 && irq == 1'b0, "R8 flag and irq cleared", int'(flags[1]), 0);

    chk(overlap == 0, "R5 pair overlap", overlap, 0);
    finish_run();
  end
endmodule